// File: doc/BRIEF.md
# Channel-to-sample word interleaver

This block takes one block of multichannel samples and reorders it for a wide streaming sink. A block holds several consecutive samples from each of several channels, arranged channel by channel. The block turns that into a sequence of output words, one per time index. Each word holds the samples that all channels took at that same instant. In the default build a block carries five 16-bit samples for each of four channels, and the block emits five 64-bit words.

A block comes in through a valid/ready handshake and is held in an internal register. The words then go out, one per accepted transfer, on a valid/ready stream of the kind a DMA FIFO accepts. The output can stall at any time. A new block may load in the same cycle that the last word of the current block is taken, so blocks can stream back to back without an idle cycle.

Top module: `sample_interleaver`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A block loads on a rising edge where `in_valid` and `in_ready` are both 1. Sample k (0..4) of channel c (0..3) sits in `in_block[(c*5+k)*16 +: 16]`.
- R3: Output word k carries sample k of channel c in bits `[c*16 +: 16]`: channel 0 in [15:0], channel 1 in [31:16], channel 2 in [47:32], channel 3 in [63:48].
- R4: After a load, the words go out in ascending sample index from 0 to 4. The index advances by one on each cycle where `out_valid` and `out_ready` are both 1.
- R5: While a block is being emitted, `in_ready` is 0, except in a cycle where the fifth word is being taken (`out_ready` is 1 on word 4).
- R6: A block offered in the cycle the fifth word is taken is loaded. Its word 0 is presented on the next cycle with `out_valid` still 1, so there is no gap.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_word` holds its value and the index does not advance.
- R8: A block offered while `in_ready` is 0 is ignored. The words of the block being emitted stay unchanged.
- R9: Once the fifth word is taken and no new block is loaded in that cycle, `out_valid` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Block can be accepted this cycle |
| in_block | input | 320 | Channel-major sample block |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Sink takes the word this cycle |
| out_word | output | 64 | One time index across all channels |

## Verification
The transposition is driven with three kinds of block. The first is a labelled block: every sample encodes its own channel and index, so any swap of lanes or indices shows up in the value. The second is a block that is all zero except one saturated sample; it can only come out right if exactly one word and one lane carry that sample. The third is a pair of differently labelled blocks sent back to back, which tells the old block's last word apart from the new block's first. Stalls on the output and blocks offered while the interleaver is busy separate holding the current word from overwriting it.

// File: rtl/il_pkg.sv
package il_pkg;
   typedef enum logic {
      IL_IDLE = 1'b0,
      IL_SEND = 1'b1
   } il_state_e;

   function automatic int il_idx_width(input int depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction
endpackage

// File: rtl/il_block_store.sv
module il_block_store #(
   parameter int SAMPLE_W = 16,
   parameter int NUM_CH   = 4,
   parameter int NUM_IDX  = 5,
   localparam int BLK_W   = SAMPLE_W * NUM_CH * NUM_IDX
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [BLK_W-1:0] blk_in,
   output logic [BLK_W-1:0] blk_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    blk_q <= '0;
      else if (load) blk_q <= blk_in;
   end
endmodule

// File: rtl/il_chunk_ctr.sv
module il_chunk_ctr
   import il_pkg::*;
#(
   parameter int NUM_IDX = 5,
   localparam int IW     = il_idx_width(NUM_IDX)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_fire,
   input  logic          out_ready,
   output logic          busy,
   output logic          last,
   output logic [IW-1:0] idx
);
   localparam logic [IW-1:0] LAST_IDX = IW'(NUM_IDX - 1);

   il_state_e state_q;
   logic      out_fire;

   assign busy     = (state_q == IL_SEND);
   assign last     = (idx == LAST_IDX);
   assign out_fire = busy && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= IL_IDLE;
         idx     <= '0;
      end else if (in_fire) begin
         state_q <= IL_SEND;
         idx     <= '0;
      end else if (out_fire) begin
         if (last) begin
            state_q <= IL_IDLE;
            idx     <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   // R4: index stays inside the block
   p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> idx <= LAST_IDX);

   // R4: a taken non-final word moves to the next index
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fire && !last && !in_fire) |=> busy && idx == $past(idx) + 1'b1);

   // R9: final word taken with no reload empties the stream
   p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fire && last && !in_fire) |=> !busy);
endmodule

// File: rtl/il_word_select.sv
module il_word_select
   import il_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int NUM_CH   = 4,
   parameter int NUM_IDX  = 5,
   localparam int BLK_W   = SAMPLE_W * NUM_CH * NUM_IDX,
   localparam int WORD_W  = SAMPLE_W * NUM_CH,
   localparam int IW      = il_idx_width(NUM_IDX)
) (
   input  logic [BLK_W-1:0]  blk,
   input  logic [IW-1:0]     idx,
   output logic [WORD_W-1:0] word
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      logic [SAMPLE_W-1:0] hist [NUM_IDX];
      for (genvar k = 0; k < NUM_IDX; k++) begin : g_tap
         assign hist[k] = blk[(c*NUM_IDX + k)*SAMPLE_W +: SAMPLE_W];
      end
      if (NUM_IDX == 1) begin : g_single
         assign word[c*SAMPLE_W +: SAMPLE_W] = hist[0];
      end else begin : g_multi
         always_comb begin
            word[c*SAMPLE_W +: SAMPLE_W] = '0;
            for (int k = 0; k < NUM_IDX; k++) begin
               if (idx == IW'(k)) word[c*SAMPLE_W +: SAMPLE_W] = hist[k];
            end
         end
      end
   end
endmodule

// File: rtl/sample_interleaver.sv
module sample_interleaver
   import il_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int NUM_CH   = 4,
   parameter int NUM_IDX  = 5,
   localparam int BLK_W   = SAMPLE_W * NUM_CH * NUM_IDX,
   localparam int WORD_W  = SAMPLE_W * NUM_CH,
   localparam int IW      = il_idx_width(NUM_IDX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [BLK_W-1:0]  in_block,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_word
);
   if (SAMPLE_W < 1) begin : g_bad_width
      $error("sample_interleaver: SAMPLE_W must be at least 1");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("sample_interleaver: NUM_CH must be at least 1");
   end
   if (NUM_IDX < 1) begin : g_bad_idx
      $error("sample_interleaver: NUM_IDX must be at least 1");
   end

   logic             busy, last, in_fire;
   logic [IW-1:0]    idx;
   logic [BLK_W-1:0] blk_q;

   assign in_ready  = !busy || (out_ready && last);
   assign in_fire   = in_valid && in_ready;
   assign out_valid = busy;

   il_block_store #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH), .NUM_IDX(NUM_IDX)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (in_fire),
      .blk_in (in_block),
      .blk_q  (blk_q)
   );

   il_chunk_ctr #(.NUM_IDX(NUM_IDX)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_fire   (in_fire),
      .out_ready (out_ready),
      .busy      (busy),
      .last      (last),
      .idx       (idx)
   );

   il_word_select #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH), .NUM_IDX(NUM_IDX)) u_sel (
      .blk  (blk_q),
      .idx  (idx),
      .word (out_word)
   );

   // R7: a stalled word stays put
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid && $stable(out_word));

   // R5: no block is accepted while the sink stalls a pending word
   p_busy_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R6: an accepted block is presented on the following cycle
   p_load_shows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
endmodule

// File: tb/tb_sample_interleaver.sv
module tb_sample_interleaver;
   localparam int CLK_PERIOD = 10;
   localparam int SW = 16;
   localparam int NC = 4;
   localparam int NI = 5;
   localparam int BW = SW * NC * NI;
   localparam int WW = SW * NC;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          in_valid = 0;
   logic          in_ready;
   logic [BW-1:0] in_block = '0;
   logic          out_valid;
   logic          out_ready = 0;
   logic [WW-1:0] out_word;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sample_interleaver dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_block(in_block), .out_valid(out_valid), .out_ready(out_ready),
      .out_word(out_word)
   );

   task automatic chk(input bit ok, input string req, input logic [WW-1:0] act,
                      input logic [WW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // R2 layout: sample k of channel c at (c*5+k)*16
   function automatic logic [BW-1:0] blk_pat(input logic [7:0] seed);
      logic [BW-1:0] b = '0;
      for (int c = 0; c < NC; c++)
         for (int k = 0; k < NI; k++)
            b[(c*NI + k)*SW +: SW] = {seed, 4'(c), 4'(k)};
      return b;
   endfunction

   function automatic logic [BW-1:0] blk_one(input int c, input int k);
      logic [BW-1:0] b = '0;
      b[(c*NI + k)*SW +: SW] = 16'hffff;
      return b;
   endfunction

   // R3 packing: channel c of word k at bits c*16
   function automatic logic [WW-1:0] exp_word(input logic [BW-1:0] b, input int k);
      logic [WW-1:0] w = '0;
      for (int c = 0; c < NC; c++) w[c*SW +: SW] = b[(c*NI + k)*SW +: SW];
      return w;
   endfunction

   task automatic load(input logic [BW-1:0] b);
      @(negedge clk);
      out_ready = 0;
      in_block  = b;
      in_valid  = 1;
      #1 chk(in_ready === 1'b1, "R2 ready before load", WW'(in_ready), 1);
      @(posedge clk);
      #1 in_valid = 0;
   endtask

   task automatic drain(input logic [BW-1:0] b, input int stall);
      for (int k = 0; k < NI; k++) begin
         for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            out_ready = 0;
            #1 chk(out_valid === 1'b1 && out_word === exp_word(b, k),
                   "R7 stalled word held", out_word, exp_word(b, k));
            chk(in_ready === 1'b0, "R5 no accept during stall", WW'(in_ready), 0);
         end
         @(negedge clk);
         out_ready = 1;
         #1 chk(out_valid === 1'b1 && out_word === exp_word(b, k),
                "R3 R4 word content and order", out_word, exp_word(b, k));
         chk(in_ready === (k == NI-1), "R5 input ready while emitting",
             WW'(in_ready), WW'(k == NI-1));
         @(posedge clk);
      end
      @(negedge clk);
      out_ready = 0;
      #1 chk(out_valid === 1'b0, "R9 stream empties", WW'(out_valid), 0);
   endtask

   task automatic t_reset();
      #1 chk(out_valid === 1'b0, "R1 out_valid after reset", WW'(out_valid), 0);
      chk(in_ready === 1'b1, "R1 in_ready after reset", WW'(in_ready), 1);
   endtask

   task automatic t_labelled();
      load(blk_pat(8'h3c));
      drain(blk_pat(8'h3c), 0);
   endtask

   task automatic t_single_sample();
      load(blk_one(3, 4));
      drain(blk_one(3, 4), 0);
      load(blk_one(0, 0));
      drain(blk_one(0, 0), 0);
      load(blk_one(2, 1));
      drain(blk_one(2, 1), 0);
   endtask

   task automatic t_stall();
      load(blk_pat(8'h51));
      drain(blk_pat(8'h51), 2);
   endtask

   task automatic t_ignore_busy();
      load(blk_pat(8'ha0));
      @(negedge clk);
      out_ready = 0;
      in_block  = blk_pat(8'hee);
      in_valid  = 1;
      #1 chk(in_ready === 1'b0, "R8 busy refuses block", WW'(in_ready), 0);
      @(posedge clk);
      #1 in_valid = 0;
      drain(blk_pat(8'ha0), 0);
   endtask

   task automatic t_back_to_back();
      load(blk_pat(8'h11));
      for (int k = 0; k < NI; k++) begin
         @(negedge clk);
         out_ready = 1;
         if (k == NI-1) begin
            in_block = blk_pat(8'h22);
            in_valid = 1;
         end
         #1 chk(out_word === exp_word(blk_pat(8'h11), k), "R6 first block words",
                out_word, exp_word(blk_pat(8'h11), k));
         if (k == NI-1)
            chk(in_ready === 1'b1, "R6 ready on last take", WW'(in_ready), 1);
         @(posedge clk);
         #1 in_valid = 0;
      end
      for (int k = 0; k < NI; k++) begin
         @(negedge clk);
         out_ready = 1;
         #1 chk(out_valid === 1'b1 && out_word === exp_word(blk_pat(8'h22), k),
                "R6 second block without gap", out_word, exp_word(blk_pat(8'h22), k));
         @(posedge clk);
      end
      @(negedge clk);
      out_ready = 0;
      #1 chk(out_valid === 1'b0, "R9 idle after second block", WW'(out_valid), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 t_reset();
      @(negedge clk);
      rst_n = 1;
      t_reset();
      t_labelled();
      t_single_sample();
      t_stall();
      t_ignore_busy();
      t_back_to_back();
      repeat (2) @(posedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule